// File: doc/BRIEF.md
# Two-Wire Bus Reset Sequencer

This block is a master-side sequencer that brings a serial EEPROM on a two-wire bus back to a known idle state. It is used after power-up, or after a command was cut off part-way. A pulse on `go` starts one of three reset patterns. The sequencer drives only open-drain pull-down enables for SCL and SDA. It never drives a line high, so a target that is still shifting out zeros or an acknowledge during the dummy clocks cannot cause contention. When the pattern is complete, both lines are left released and the bus passes to a normal command engine.

Bus timing comes from a clock-enable `tick`. Every SCL-low phase lasts `lo_len` ticks and every SCL-high phase lasts `hi_len` ticks. A length of zero counts as one tick. The walk through a pattern is held in an enumerated state register:

- `ST_IDLE`: lines released.
- `ST_DLO`, `ST_DHI`: the two halves of a dummy clock, with SDA released.
- `ST_PLO`: SCL low, SDA released. This is the set-up before a START.
- `ST_PHI`: SCL high, SDA released.
- `ST_PFALL`: SDA pulled low while SCL is high. This is the START.
- `ST_PLOCK`: SCL pulled low while SDA is still held.
- `ST_FLO`, `ST_FHI`: one closing clock with SDA released.

The transitions are as follows:

- Accept: `ST_IDLE` goes to the first segment of the pattern.
- Phase end: each state moves to the next state in its element.
- Repeat: `ST_DHI` goes to `ST_DLO`, and `ST_PLOCK` goes to `ST_PLO`, while repeats remain.
- Advance: the last element of a segment goes to the entry state of the next segment.
- Finish: `ST_FHI` goes to `ST_IDLE` and pulses `done`.

Top module: `bus_recover_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `scl_oe` and `sda_oe` are all 0, so both lines are released.
- R2: Mode 2'b00 issues 14 dummy clocks, then 2 STARTs, then one closing clock. That is 17 SCL rising edges and 2 START events. The first START follows the 15th rising edge.
- R3: Mode 2'b01 issues a START, then 9 dummy clocks, then a second START, then one closing clock. That is 12 rising edges and 2 STARTs. The first START follows the 1st rising edge.
- R4: Mode 2'b10 issues 9 STARTs back to back, then one closing clock. That is 10 rising edges and 9 STARTs. The first START follows the 1st rising edge.
- R5: Mode 2'b11 behaves exactly like mode 2'b00.
- R6: `sda_oe` stays 0 from the acceptance of `go` until the first START. A target pulling SDA low during the dummy clocks causes no START or STOP to be seen.
- R7: SCL and SDA never change in the same clock cycle. No STOP condition (SDA rising while SCL is high) appears while the block is busy.
- R8: An SCL-low phase lasts `lo_len` ticks and an SCL-high phase lasts `hi_len` ticks, with 0 treated as 1. When `tick` is high every cycle, the first low and high phases of mode 2'b00 last `lo_len` and `hi_len` cycles.
- R9: While `tick` is low, no phase advances. After acceptance SCL stays pulled low and SDA stays released.
- R10: `done` is high for exactly one cycle per sequence. In that cycle `busy` is 0 and both lines are released.
- R11: A `go` that arrives while `busy` is 1 is ignored. The running pattern completes unchanged and `done` pulses only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable that paces the bus phases |
| go | input | 1 | Start request, accepted only when idle |
| mode | input | 2 | Pattern select: 00 long dummy, 01 sandwich, 10 START burst, 11 same as 00 |
| hi_len | input | TICK_W | SCL-high phase length in ticks |
| lo_len | input | TICK_W | SCL-low phase length in ticks |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench watches the bus after the open-drain resolution and counts SCL rising edges, STARTs and STOPs for every mode. A wrong segment table or an off-by-one in the repeat counter therefore shows up directly as a wrong count or a misplaced first START.

A target model pulls SDA low across several dummy clocks. A design that drove SDA, or that reordered its edges, would produce phantom STARTs or STOPs. Zero-length phases and a stalled tick are exercised as well. A timer that wrapped, or that ignored the enable, would stretch phases or run on without ticks. A second `go` sent mid-sequence catches a design that restarts or switches pattern.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DLO,
        ST_DHI,
        ST_PLO,
        ST_PHI,
        ST_PFALL,
        ST_PLOCK,
        ST_FLO,
        ST_FHI
    } state_t;

    typedef enum logic [1:0] {
        K_DUMMY,
        K_START,
        K_END
    } kind_t;

    typedef enum logic [1:0] {
        PAT_LONG,
        PAT_SANDWICH,
        PAT_BURST
    } pattern_t;

    function automatic pattern_t decode_mode(input logic [1:0] m);
        pattern_t p;
        unique case (m)
            2'b01:   p = PAT_SANDWICH;
            2'b10:   p = PAT_BURST;
            default: p = PAT_LONG;
        endcase
        return p;
    endfunction

    // States whose phase holds SCL low take the low-phase length.
    function automatic logic scl_low_in(input state_t s);
        return (s == ST_DLO) || (s == ST_PLO) || (s == ST_PLOCK) || (s == ST_FLO);
    endfunction

endpackage

// File: rtl/busrec_timer.sv
module busrec_timer #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [TICK_W-1:0] len,
    output logic              expire
);
    logic [TICK_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (len == '0) ? '0 : len - 1'b1;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = tick && (cnt == '0);

    assert_phase_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));

endmodule

// File: rtl/busrec_repcnt.sv
module busrec_repcnt #(
    parameter int REP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REP_W-1:0] load_val,
    input  logic             step,
    output logic             last
);
    logic [REP_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (step && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);

    assert_rep_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/busrec_plan.sv
module busrec_plan
    import busrec_pkg::*;
#(
    parameter int REP_W        = 4,
    parameter int N_LONG_DUMMY = 14,
    parameter int N_LONG_START = 2,
    parameter int N_SHORT_DUMMY = 9,
    parameter int N_BURST      = 9
) (
    input  pattern_t         pat,
    input  logic [1:0]       seg,
    output kind_t            kind,
    output logic [REP_W-1:0] reps
);
    localparam logic [REP_W-1:0] R_LONG_D  = REP_W'(N_LONG_DUMMY);
    localparam logic [REP_W-1:0] R_LONG_S  = REP_W'(N_LONG_START);
    localparam logic [REP_W-1:0] R_SHORT_D = REP_W'(N_SHORT_DUMMY);
    localparam logic [REP_W-1:0] R_BURST   = REP_W'(N_BURST);
    localparam logic [REP_W-1:0] R_ONE     = REP_W'(1);

    always_comb begin
        kind = K_END;
        reps = R_ONE;
        unique case (pat)
            PAT_LONG: begin
                if (seg == 2'd0) begin
                    kind = K_DUMMY; reps = R_LONG_D;
                end else if (seg == 2'd1) begin
                    kind = K_START; reps = R_LONG_S;
                end
            end
            PAT_SANDWICH: begin
                if (seg == 2'd0 || seg == 2'd2) begin
                    kind = K_START; reps = R_ONE;
                end else if (seg == 2'd1) begin
                    kind = K_DUMMY; reps = R_SHORT_D;
                end
            end
            PAT_BURST: begin
                if (seg == 2'd0) begin
                    kind = K_START; reps = R_BURST;
                end
            end
            default: begin
                kind = K_END;
                reps = R_ONE;
            end
        endcase
    end

endmodule

// File: rtl/bus_recover_seq.sv
module bus_recover_seq
    import busrec_pkg::*;
#(
    parameter int TICK_W        = 8,
    parameter int N_LONG_DUMMY  = 14,
    parameter int N_LONG_START  = 2,
    parameter int N_SHORT_DUMMY = 9,
    parameter int N_BURST       = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go,
    input  logic [1:0]        mode,
    input  logic [TICK_W-1:0] hi_len,
    input  logic [TICK_W-1:0] lo_len,
    output logic              busy,
    output logic              done,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int MAX_AB  = (N_LONG_DUMMY > N_SHORT_DUMMY) ? N_LONG_DUMMY : N_SHORT_DUMMY;
    localparam int MAX_CD  = (N_BURST > N_LONG_START) ? N_BURST : N_LONG_START;
    localparam int MAX_REP = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int REP_W   = $clog2(MAX_REP + 1);

    state_t            state, nstate;
    pattern_t          pat, lk_pat;
    logic [1:0]        seg, lk_seg;
    kind_t             lk_kind;
    logic [REP_W-1:0]  lk_reps;
    logic              expire, rep_last;
    logic              rep_load, rep_step, seg_adv, accept;
    logic              tmr_load;
    logic [TICK_W-1:0] tmr_len;

    // Segment lookup: the first segment while idle, otherwise the next one.
    assign lk_pat = (state == ST_IDLE) ? decode_mode(mode) : pat;
    assign lk_seg = (state == ST_IDLE) ? 2'd0 : 2'(seg + 2'd1);

    busrec_plan #(
        .REP_W(REP_W),
        .N_LONG_DUMMY(N_LONG_DUMMY),
        .N_LONG_START(N_LONG_START),
        .N_SHORT_DUMMY(N_SHORT_DUMMY),
        .N_BURST(N_BURST)
    ) u_plan (
        .pat (lk_pat),
        .seg (lk_seg),
        .kind(lk_kind),
        .reps(lk_reps)
    );

    busrec_timer #(.TICK_W(TICK_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .load  (tmr_load),
        .len   (tmr_len),
        .expire(expire)
    );

    busrec_repcnt #(.REP_W(REP_W)) u_rep (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rep_load),
        .load_val(lk_reps),
        .step    (rep_step),
        .last    (rep_last)
    );

    function automatic state_t entry_of(input kind_t k);
        state_t s;
        unique case (k)
            K_DUMMY: s = ST_DLO;
            K_START: s = ST_PLO;
            default: s = ST_FLO;
        endcase
        return s;
    endfunction

    assign accept = (state == ST_IDLE) && go;

    // Next-state logic
    always_comb begin
        nstate   = state;
        rep_load = 1'b0;
        rep_step = 1'b0;
        seg_adv  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    nstate   = entry_of(lk_kind);
                    rep_load = 1'b1;
                end
            end
            ST_DLO:   if (expire) nstate = ST_DHI;
            ST_DHI: begin
                if (expire) begin
                    if (rep_last) begin
                        nstate   = entry_of(lk_kind);
                        rep_load = 1'b1;
                        seg_adv  = 1'b1;
                    end else begin
                        nstate   = ST_DLO;
                        rep_step = 1'b1;
                    end
                end
            end
            ST_PLO:   if (expire) nstate = ST_PHI;
            ST_PHI:   if (expire) nstate = ST_PFALL;
            ST_PFALL: if (expire) nstate = ST_PLOCK;
            ST_PLOCK: begin
                if (expire) begin
                    if (rep_last) begin
                        nstate   = entry_of(lk_kind);
                        rep_load = 1'b1;
                        seg_adv  = 1'b1;
                    end else begin
                        nstate   = ST_PLO;
                        rep_step = 1'b1;
                    end
                end
            end
            ST_FLO:   if (expire) nstate = ST_FHI;
            ST_FHI:   if (expire) nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    assign tmr_load = (nstate != state);
    assign tmr_len  = scl_low_in(nstate) ? lo_len : hi_len;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pat   <= PAT_LONG;
            seg   <= 2'd0;
            done  <= 1'b0;
        end else begin
            state <= nstate;
            done  <= (state == ST_FHI) && expire;
            if (accept) begin
                pat <= decode_mode(mode);
                seg <= 2'd0;
            end else if (seg_adv) begin
                seg <= 2'(seg + 2'd1);
            end
        end
    end

    // Output decode
    always_comb begin
        busy   = 1'b1;
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_DLO:   scl_oe = 1'b1;
            ST_DHI:   scl_oe = 1'b0;
            ST_PLO:   scl_oe = 1'b1;
            ST_PHI:   scl_oe = 1'b0;
            ST_PFALL: sda_oe = 1'b1;
            ST_PLOCK: begin scl_oe = 1'b1; sda_oe = 1'b1; end
            ST_FLO:   scl_oe = 1'b1;
            ST_FHI:   scl_oe = 1'b0;
            default:  busy = 1'b0;
        endcase
    end

    assert_no_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !scl_oe && $past(!scl_oe)) |-> !($past(sda_oe) && !sda_oe));

    assert_one_line_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_oe) |-> $stable(sda_oe));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !scl_oe && !sda_oe));

    assert_busy_go_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go) |=> (pat == $past(pat)));

endmodule

// File: tb/bus_recover_seq_test.sv
module bus_recover_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b1;
    logic          go = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [TW-1:0] hi_len = 8'd2;
    logic [TW-1:0] lo_len = 8'd2;
    logic          busy, done, scl_oe, sda_oe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    bus_recover_seq #(.TICK_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .mode(mode),
        .hi_len(hi_len), .lo_len(lo_len),
        .busy(busy), .done(done), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bus monitor and target model
    int   run_id = 0, cur_id = 0;
    logic pull_en = 1'b0;
    logic tgt_pull = 1'b0;
    logic p_scl = 1'b1, p_sda = 1'b1, s_scl, s_sda;
    int   m_rises, m_starts, m_stops, m_dones, m_drv, m_rise_at_start;
    int   m_first_lo, m_first_hi, m_run;
    logic m_seen_fall;

    always @(negedge clk) begin
        if (run_id != cur_id) begin
            cur_id = run_id;
            m_rises = 0; m_starts = 0; m_stops = 0; m_dones = 0; m_drv = 0;
            m_rise_at_start = -1; m_first_lo = 0; m_first_hi = 0; m_run = 1;
            m_seen_fall = 1'b0; tgt_pull = 1'b0;
        end
        s_scl = !scl_oe;
        s_sda = !sda_oe && !tgt_pull;
        if (rst_n) begin
            if (!p_scl && s_scl) m_rises++;
            if (p_scl && s_scl && p_sda && !s_sda) begin
                if (m_starts == 0) m_rise_at_start = m_rises;
                m_starts++;
            end
            if (p_scl && s_scl && !p_sda && s_sda) m_stops++;
            if (m_starts == 0 && sda_oe) m_drv++;
            if (done) m_dones++;
            if (s_scl != p_scl) begin
                if (s_scl && m_first_lo == 0) m_first_lo = m_run;
                if (!s_scl) begin
                    if (m_seen_fall && m_first_hi == 0) m_first_hi = m_run;
                    m_seen_fall = 1'b1;
                    if (pull_en && m_rises == 2) tgt_pull = 1'b1;
                    if (pull_en && m_rises == 5) tgt_pull = 1'b0;
                end
                m_run = 1;
            end else begin
                m_run++;
            end
        end
        p_scl = s_scl;
        p_sda = s_sda;
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic new_run();
        step();
        run_id++;
        step();
    endtask

    task automatic pulse_go(input logic [1:0] m);
        mode = m;
        go   = 1'b1;
        step();
        go   = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000 && m_dones == 0; i++) step();
    endtask

    task automatic check_end(input string req);
        check(!busy && !scl_oe && !sda_oe, {req, " idle lines at done"},
              {busy, scl_oe, sda_oe}, 0);
        step(); step();
        check(m_dones == 1 && !done, {req, " R10 single done"}, m_dones, 1);
        check(m_stops == 0, {req, " R7 no stop"}, m_stops, 0);
    endtask

    task automatic test_reset_R1();
        step();
        check(!busy && !done && !scl_oe && !sda_oe, "R1 reset state",
              {busy, done, scl_oe, sda_oe}, 0);
    endtask

    task automatic test_pattern(input logic [1:0] m, input string req,
                                input int e_rises, input int e_starts, input int e_first);
        hi_len = 8'd2; lo_len = 8'd2;
        new_run();
        pulse_go(m);
        wait_done();
        check(m_rises == e_rises, {req, " rising edges"}, m_rises, e_rises);
        check(m_starts == e_starts, {req, " starts"}, m_starts, e_starts);
        check(m_rise_at_start == e_first, {req, " first start position"},
              m_rise_at_start, e_first);
        check_end(req);
    endtask

    task automatic test_target_pull_R6();
        hi_len = 8'd3; lo_len = 8'd4;
        pull_en = 1'b1;
        new_run();
        pulse_go(2'b00);
        wait_done();
        pull_en = 1'b0;
        check(m_drv == 0, "R6 sda not driven before first start", m_drv, 0);
        check(m_starts == 2, "R6 starts with target pulling", m_starts, 2);
        check(m_first_lo == 4, "R8 first low phase", m_first_lo, 4);
        check(m_first_hi == 3, "R8 first high phase", m_first_hi, 3);
        check_end("R6");
    endtask

    task automatic test_zero_len_R8();
        hi_len = 8'd0; lo_len = 8'd0;
        new_run();
        pulse_go(2'b00);
        wait_done();
        check(m_first_lo == 1, "R8 zero low length", m_first_lo, 1);
        check(m_first_hi == 1, "R8 zero high length", m_first_hi, 1);
        check(m_rises == 17, "R8 zero length rises", m_rises, 17);
    endtask

    task automatic test_stall_R9();
        hi_len = 8'd2; lo_len = 8'd2;
        tick = 1'b0;
        new_run();
        pulse_go(2'b10);
        for (int i = 0; i < 30; i++) step();
        check(busy && scl_oe && !sda_oe && m_rises == 0, "R9 frozen without tick",
              m_rises, 0);
        tick = 1'b1;
        wait_done();
        check(m_starts == 9, "R9 completes after tick resumes", m_starts, 9);
    endtask

    task automatic test_busy_go_R11();
        hi_len = 8'd2; lo_len = 8'd2;
        new_run();
        pulse_go(2'b00);
        for (int i = 0; i < 20; i++) step();
        pulse_go(2'b10);
        wait_done();
        check(m_rises == 17, "R11 rises unchanged", m_rises, 17);
        check(m_starts == 2, "R11 starts unchanged", m_starts, 2);
        for (int i = 0; i < 10; i++) step();
        check(m_dones == 1 && !busy, "R11 no restart", m_dones, 1);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) step();
        rst_n = 1'b1;
        test_reset_R1();
        test_pattern(2'b00, "R2", 17, 2, 15);
        test_pattern(2'b01, "R3", 12, 2, 1);
        test_pattern(2'b10, "R4", 10, 9, 1);
        test_pattern(2'b11, "R5", 17, 2, 15);
        test_target_pull_R6();
        test_zero_len_R8();
        test_stall_R9();
        test_busy_go_R11();
        finish_run();
    end

endmodule